// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox Slot Bank

This block holds a bank of mailbox slots through which two processors exchange fixed-length messages. Each slot carries a control register and a run of message words. Both the local processor and the remote processor reach every slot through their own word-addressed register port, made up of address, write enable, write data and read data. A slot's control register holds a one-hot handshake state and a bit that selects how the acknowledge is handled.

A sender marks the slot as transmitting, picks the acknowledge style and fills the message words. When the far side has consumed the message, it writes the acknowledge state into the slot's control register. In automatic style, the slot drops back to idle by itself one clock later and raises nothing, so a polling sender simply waits for idle. In interrupt style, the slot holds the acknowledge state and emits a one-cycle pulse on its own event line for the interrupt logic.

Top module: `mbx_bank`

## Requirements
- R1: After reset, every slot's control register reads 0x10 (idle state, interrupt acknowledge style) and every message word reads zero.
- R2: Word address bits [8:4] select the slot and bits [3:0] the word inside the slot. Offset 0 is the control register and offsets 1 to 8 are message words 0 to 7. Either port reads back what either port wrote, and the read data is combinational on the address.
- R3: In the control register, bits [7:4] hold the state (0x1 idle, 0x2 transmit, 0x4 receive, 0x8 acknowledge) and bit 0 holds the acknowledge style (1 automatic, 0 interrupt). All other bits read zero, whatever value was written to them.
- R4: A control write whose bits [7:4] are not one-hot leaves the state unchanged but still updates bit 0.
- R5: When the remote port writes state 0x8 with bit 0 set, the slot reads acknowledge for exactly one cycle and then idle, and its event line stays low. A control write in that cycle takes precedence over the return to idle.
- R6: When the remote port writes state 0x8 with bit 0 clear, the slot's bit of ack_evt_o is high for exactly the one cycle after the write, and the state stays at acknowledge until it is written again.
- R7: A local write of state 0x8 neither pulses the event line nor returns the slot to idle.
- R8: When both ports write the same word in the same cycle, the local write takes effect and the remote write is discarded, including any acknowledge it carried.
- R9: Offsets 9 to 15 of a slot read zero, and writes to them change nothing.
- R10: A write to one slot changes no other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| loc_addr_i | input | 9 | Local port word address |
| loc_we_i | input | 1 | Local port write enable |
| loc_wdata_i | input | 32 | Local port write data |
| loc_rdata_o | output | 32 | Local port read data |
| rem_addr_i | input | 9 | Remote port word address |
| rem_we_i | input | 1 | Remote port write enable |
| rem_wdata_i | input | 32 | Remote port write data |
| rem_rdata_o | output | 32 | Remote port read data |
| ack_evt_o | output | 32 | Per-slot acknowledge event pulse |

## Verification
The bench targets four corner cases:

- **Automatic return to idle.** The bench checks the single cycle in which the acknowledge state is visible, and it writes the control register in the very next cycle. A design that returned a cycle late, or that let the return override a fresh write, would read the wrong state.
- **Same-word collisions between the ports.** If the remote write were allowed to win or to merge, the bench would see the remote data, or an event pulse that should not exist.
- **Non-one-hot state values.** A design that stored such a value would fail the one-hot read-back. A design that dropped the whole write would lose the style bit.
- **Unmapped offsets and neighbouring slots.** Writes there would show up as non-zero reads, or as corrupted words in other slots.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'h1,
    ST_TX   = 4'h2,
    ST_RX   = 4'h4,
    ST_ACK  = 4'h8
  } slot_state_e;

  localparam int unsigned STATE_LSB = 4;
  localparam int unsigned AMODE_BIT = 0;

  function automatic logic is_onehot4(input logic [3:0] v);
    return (v != 4'h0) && ((v & (v - 4'h1)) == 4'h0);
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned MSG_WORDS = 8,
  localparam int unsigned WI_W     = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1
) (
  input  logic [SLOT_W+OFF_W-1:0] addr_i,
  output logic [SLOT_W-1:0]       slot_o,
  output logic                    is_mode_o,
  output logic                    is_data_o,
  output logic [WI_W-1:0]         widx_o
);
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] off_m1;

  assign off       = addr_i[OFF_W-1:0];
  assign slot_o    = addr_i[SLOT_W+OFF_W-1:OFF_W];
  assign off_m1    = off - OFF_W'(1);
  assign is_mode_o = (off == '0);
  assign is_data_o = (off != '0) && (int'(off) <= MSG_WORDS);
  assign widx_o    = off_m1[WI_W-1:0];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MSG_WORDS = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                loc_mode_we_i,
  input  logic [3:0]                          loc_state_i,
  input  logic                                loc_amode_i,
  input  logic                                rem_mode_we_i,
  input  logic [3:0]                          rem_state_i,
  input  logic                                rem_amode_i,
  input  logic [MSG_WORDS-1:0]                loc_data_we_i,
  input  logic [MSG_WORDS-1:0]                rem_data_we_i,
  input  logic [DATA_W-1:0]                   loc_wdata_i,
  input  logic [DATA_W-1:0]                   rem_wdata_i,
  output logic [3:0]                          state_o,
  output logic                                amode_o,
  output logic [MSG_WORDS-1:0][DATA_W-1:0]    data_o,
  output logic                                ack_evt_o
);
  logic [3:0] state_q;
  logic       amode_q;
  logic       auto_q;
  logic       evt_q;
  logic       rem_mode_win;
  logic       any_mode_we;
  logic       rem_ack_wr;

  // local port wins a same-register collision
  assign rem_mode_win = rem_mode_we_i && !loc_mode_we_i;
  assign any_mode_we  = loc_mode_we_i || rem_mode_we_i;
  assign rem_ack_wr   = rem_mode_win && (rem_state_i == ST_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      amode_q <= 1'b0;
      auto_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      auto_q <= rem_ack_wr && rem_amode_i;
      evt_q  <= rem_ack_wr && !rem_amode_i;
      if (loc_mode_we_i) begin
        amode_q <= loc_amode_i;
        if (is_onehot4(loc_state_i)) state_q <= loc_state_i;
      end else if (rem_mode_win) begin
        amode_q <= rem_amode_i;
        if (is_onehot4(rem_state_i)) state_q <= rem_state_i;
      end else if (auto_q) begin
        state_q <= ST_IDLE;
      end
    end
  end

  for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                word_q <= '0;
      else if (loc_data_we_i[w])  word_q <= loc_wdata_i;
      else if (rem_data_we_i[w])  word_q <= rem_wdata_i;
    end
    assign data_o[w] = word_q;
  end

  assign state_o   = state_q;
  assign amode_o   = amode_q;
  assign ack_evt_o = evt_q;

  // R4
  state_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_onehot4(state_q));
  // R6
  evt_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (state_q == ST_ACK) && !amode_q);
  // R5
  auto_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_q && !any_mode_we) |=> (state_q == ST_IDLE));
  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_mode_we && !auto_q) |=> $stable(state_q) && $stable(amode_q));
  // R8
  collide_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_mode_we_i && rem_mode_we_i) |=> !evt_q && !auto_q);
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_WORDS = 16,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned OFF_W    = $clog2(WIN_WORDS),
  localparam int unsigned ADDR_W   = SLOT_W + OFF_W,
  localparam int unsigned WI_W     = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     loc_addr_i,
  input  logic                  loc_we_i,
  input  logic [DATA_W-1:0]     loc_wdata_i,
  output logic [DATA_W-1:0]     loc_rdata_o,
  input  logic [ADDR_W-1:0]     rem_addr_i,
  input  logic                  rem_we_i,
  input  logic [DATA_W-1:0]     rem_wdata_i,
  output logic [DATA_W-1:0]     rem_rdata_o,
  output logic [NUM_SLOTS-1:0]  ack_evt_o
);
  logic [SLOT_W-1:0] loc_slot, rem_slot;
  logic              loc_is_mode, loc_is_data, rem_is_mode, rem_is_data;
  logic [WI_W-1:0]   loc_widx, rem_widx;
  logic [MSG_WORDS-1:0] loc_wvec, rem_wvec;

  logic [DATA_W-1:0]                mode_word [NUM_SLOTS];
  logic [MSG_WORDS-1:0][DATA_W-1:0] slot_data [NUM_SLOTS];

  mbx_decode #(.SLOT_W(SLOT_W), .OFF_W(OFF_W), .MSG_WORDS(MSG_WORDS)) u_loc_dec (
    .addr_i(loc_addr_i), .slot_o(loc_slot), .is_mode_o(loc_is_mode),
    .is_data_o(loc_is_data), .widx_o(loc_widx)
  );

  mbx_decode #(.SLOT_W(SLOT_W), .OFF_W(OFF_W), .MSG_WORDS(MSG_WORDS)) u_rem_dec (
    .addr_i(rem_addr_i), .slot_o(rem_slot), .is_mode_o(rem_is_mode),
    .is_data_o(rem_is_data), .widx_o(rem_widx)
  );

  always_comb begin
    loc_wvec = '0;
    rem_wvec = '0;
    if (loc_we_i && loc_is_data) loc_wvec[loc_widx] = 1'b1;
    if (rem_we_i && rem_is_data) rem_wvec[rem_widx] = 1'b1;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic       loc_hit, rem_hit;
    logic [3:0] st;
    logic       am;

    assign loc_hit = loc_we_i && (loc_slot == SLOT_W'(g));
    assign rem_hit = rem_we_i && (rem_slot == SLOT_W'(g));

    mbx_slot #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .loc_mode_we_i (loc_hit && loc_is_mode),
      .loc_state_i   (loc_wdata_i[STATE_LSB+:4]),
      .loc_amode_i   (loc_wdata_i[AMODE_BIT]),
      .rem_mode_we_i (rem_hit && rem_is_mode),
      .rem_state_i   (rem_wdata_i[STATE_LSB+:4]),
      .rem_amode_i   (rem_wdata_i[AMODE_BIT]),
      .loc_data_we_i (loc_hit ? loc_wvec : '0),
      .rem_data_we_i (rem_hit ? rem_wvec : '0),
      .loc_wdata_i   (loc_wdata_i),
      .rem_wdata_i   (rem_wdata_i),
      .state_o       (st),
      .amode_o       (am),
      .data_o        (slot_data[g]),
      .ack_evt_o     (ack_evt_o[g])
    );

    always_comb begin
      mode_word[g]                = '0;
      mode_word[g][STATE_LSB+:4]  = st;
      mode_word[g][AMODE_BIT]     = am;
    end
  end

  always_comb begin
    loc_rdata_o = '0;
    if (int'(loc_slot) < NUM_SLOTS) begin
      if (loc_is_mode)      loc_rdata_o = mode_word[loc_slot];
      else if (loc_is_data) loc_rdata_o = slot_data[loc_slot][loc_widx];
    end
  end

  always_comb begin
    rem_rdata_o = '0;
    if (int'(rem_slot) < NUM_SLOTS) begin
      if (rem_is_mode)      rem_rdata_o = mode_word[rem_slot];
      else if (rem_is_data) rem_rdata_o = slot_data[rem_slot][rem_widx];
    end
  end

  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loc_is_mode && !loc_is_data) |-> (loc_rdata_o == '0));
  // R3
  mode_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_is_mode |-> ((rem_rdata_o & ~DATA_W'(32'hF1)) == '0));
endmodule

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  loc_addr = '0, rem_addr = '0;
  logic        loc_we = 1'b0, rem_we = 1'b0;
  logic [31:0] loc_wd = '0, rem_wd = '0;
  logic [31:0] loc_rd, rem_rd, evt;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mbx_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .loc_addr_i(loc_addr), .loc_we_i(loc_we), .loc_wdata_i(loc_wd), .loc_rdata_o(loc_rd),
    .rem_addr_i(rem_addr), .rem_we_i(rem_we), .rem_wdata_i(rem_wd), .rem_rdata_o(rem_rd),
    .ack_evt_o(evt)
  );

  // reference model
  logic [3:0]  m_st [32];
  logic        m_am [32];
  logic [31:0] m_dt [32][8];
  logic        m_ap [32];
  logic [31:0] m_ev;

  function automatic logic [8:0] mk(input int s, input int o);
    return {s[4:0], o[3:0]};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [8:0] a);
    int s = int'(a[8:4]);
    int o = int'(a[3:0]);
    if (o == 0) return {24'h0, m_st[s], 3'b000, m_am[s]};
    if (o <= 8) return m_dt[s][o-1];
    return 32'h0;
  endfunction

  function automatic logic onehot(input logic [3:0] v);
    return (v != 0) && ((v & (v - 4'h1)) == 0);
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 32; s++) begin
      m_st[s] = 4'h1; m_am[s] = 1'b0; m_ap[s] = 1'b0;
      for (int w = 0; w < 8; w++) m_dt[s][w] = '0;
    end
    m_ev = '0;
  endtask

  task automatic apply(input logic [8:0] a, input logic [31:0] d, input logic remote,
                       inout logic [31:0] nev, inout logic [31:0] nap);
    int s = int'(a[8:4]);
    int o = int'(a[3:0]);
    if (o == 0) begin
      m_am[s] = d[0];
      if (onehot(d[7:4])) m_st[s] = d[7:4];
      if (remote && d[7:4] == 4'h8) begin
        if (d[0]) nap[s] = 1'b1;
        else      nev[s] = 1'b1;
      end
    end else if (o <= 8) begin
      m_dt[s][o-1] = d;
    end
  endtask

  task automatic model_step(input logic [8:0] la, input logic lw, input logic [31:0] lwd,
                            input logic [8:0] ra, input logic rw, input logic [31:0] rwd);
    logic [31:0] nev = '0;
    logic [31:0] nap = '0;
    for (int s = 0; s < 32; s++) begin
      logic mw = (lw && la == mk(s, 0)) || (rw && ra == mk(s, 0));
      if (m_ap[s] && !mw) m_st[s] = 4'h1;
    end
    if (rw && !(lw && la == ra)) apply(ra, rwd, 1'b1, nev, nap);
    if (lw) apply(la, lwd, 1'b0, nev, nap);
    for (int s = 0; s < 32; s++) m_ap[s] = nap[s];
    m_ev = nev;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] la, input logic lw, input logic [31:0] lwd,
                      input logic [8:0] ra, input logic rw, input logic [31:0] rwd);
    @(negedge clk);
    loc_addr = la; loc_we = lw; loc_wd = lwd;
    rem_addr = ra; rem_we = rw; rem_wd = rwd;
    #1;
    chk("local read", loc_rd, exp_rd(la));
    chk("remote read", rem_rd, exp_rd(ra));
    chk("ack events", evt, m_ev);
    @(posedge clk);
    model_step(la, lw, lwd, ra, rw, rwd);
  endtask

  task automatic rd(input logic [8:0] la, input logic [8:0] ra);
    step(la, 1'b0, '0, ra, 1'b0, '0);
  endtask

  function automatic logic [31:0] rnd_word(input logic [3:0] off);
    logic [31:0] r = $urandom;
    logic [3:0] st;
    case ($urandom % 6)
      0: st = 4'h1; 1: st = 4'h2; 2: st = 4'h4; 3, 4: st = 4'h8;
      default: st = r[11:8];
    endcase
    if (off == 0) r[7:4] = st;
    return r;
  endfunction

  function automatic logic [8:0] rnd_addr();
    int sl[4] = '{0, 1, 2, 31};
    return mk(sl[$urandom % 4], int'($urandom % 16));
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    for (int s = 0; s < 32; s++) rd(mk(s, 0), mk(s, 1 + (s % 8)));

    cur_req = "R2";
    for (int w = 0; w < 8; w++) step(mk(3, w + 1), 1'b1, 32'hA500_0000 + w, mk(0, 0), 1'b0, '0);
    for (int w = 0; w < 8; w++) rd(mk(3, w + 1), mk(3, 8 - w));
    step(mk(0, 0), 1'b0, '0, mk(4, 2), 1'b1, 32'hDEAD_BEEF);
    rd(mk(4, 2), mk(4, 2));

    cur_req = "R3";
    step(mk(8, 0), 1'b1, 32'hFFFF_FF2F, mk(0, 0), 1'b0, '0);
    rd(mk(8, 0), mk(8, 0));

    cur_req = "R4";
    step(mk(8, 0), 1'b1, 32'h0000_0030, mk(0, 0), 1'b0, '0);
    rd(mk(8, 0), mk(8, 0));
    step(mk(0, 0), 1'b0, '0, mk(8, 0), 1'b1, 32'h0000_00F1);
    rd(mk(8, 0), mk(8, 0));

    cur_req = "R5";
    step(mk(0, 0), 1'b0, '0, mk(5, 0), 1'b1, 32'h0000_0081);
    rd(mk(5, 0), mk(5, 0));
    rd(mk(5, 0), mk(5, 0));
    step(mk(0, 0), 1'b0, '0, mk(5, 0), 1'b1, 32'h0000_0081);
    step(mk(5, 0), 1'b1, 32'h0000_0041, mk(5, 0), 1'b0, '0);
    rd(mk(5, 0), mk(5, 0));

    cur_req = "R6";
    step(mk(0, 0), 1'b0, '0, mk(6, 0), 1'b1, 32'h0000_0080);
    rd(mk(6, 0), mk(6, 0));
    rd(mk(6, 0), mk(6, 0));
    rd(mk(6, 0), mk(6, 0));

    cur_req = "R7";
    step(mk(7, 0), 1'b1, 32'h0000_0081, mk(0, 0), 1'b0, '0);
    rd(mk(7, 0), mk(7, 0));
    step(mk(7, 0), 1'b1, 32'h0000_0080, mk(0, 0), 1'b0, '0);
    rd(mk(7, 0), mk(7, 0));
    rd(mk(7, 0), mk(7, 0));

    cur_req = "R8";
    step(mk(9, 0), 1'b1, 32'h0000_0021, mk(9, 0), 1'b1, 32'h0000_0080);
    rd(mk(9, 0), mk(9, 0));
    step(mk(9, 3), 1'b1, 32'h1111_1111, mk(9, 3), 1'b1, 32'h2222_2222);
    rd(mk(9, 3), mk(9, 3));

    cur_req = "R9";
    step(mk(2, 12), 1'b1, 32'hFFFF_FFFF, mk(2, 9), 1'b1, 32'h1234_5678);
    for (int o = 0; o < 16; o++) rd(mk(2, o), mk(2, 15 - o));

    cur_req = "R10";
    step(mk(10, 4), 1'b1, 32'hCAFE_0001, mk(11, 0), 1'b1, 32'h0000_0041);
    for (int s = 9; s < 13; s++) rd(mk(s, 0), mk(s, 4));

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] la = rnd_addr();
      logic [8:0] ra = ($urandom % 4 == 0) ? la : rnd_addr();
      step(la, 1'($urandom % 2), rnd_word(la[3:0]),
           ra, 1'($urandom % 2), rnd_word(ra[3:0]));
    end
    for (int s = 0; s < 32; s++) rd(mk(s, 0), mk(s, 1 + (s % 8)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule